// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two square-wave outputs of an incremental rotary or linear encoder into a position count. Each raw input is first brought into the clock domain by a two-flop synchronizer. A digital filter then passes a level change on only after the synchronized value has stayed at the new level for a programmable number of consecutive cycles. Each change of the filtered signal pair is classified as a forward step, a reverse step or an illegal double change, using the Gray-code order of the two-bit state.

A mode input chooses which transitions move the counter. The choices are edges of channel A only, edges of channel B only, edges of both channels (four counts per encoder line), or none. The count runs from zero up to a programmable limit and wraps at both ends. Each wrap raises a one-cycle overflow or underflow pulse. A direction flag holds the sense of the most recent counted step. An illegal double change leaves the count alone and raises a one-cycle error pulse.

Top module: `quad_pos_counter`

## Requirements
- R1: While `rstN` is low, `count` is 0, `dirUp` is 1 and `ovfPulse`, `unfPulse` and `errPulse` are 0.
- R2: The state pair is (B,A), with B the high bit. The forward order is 00→01→11→10→00. With `mode` = 2'b11, every forward single-bit change adds one to `count` and every reverse single-bit change subtracts one.
- R3: With `mode` = 2'b01, only changes of channel A move the count. Changes of channel B leave `count` and `dirUp` unchanged.
- R4: With `mode` = 2'b10, only changes of channel B move the count. Changes of channel A leave `count` and `dirUp` unchanged.
- R5: With `mode` = 2'b00, no transition changes `count` or `dirUp`.
- R6: A raw input change is accepted only after it has held for `filtLen` consecutive synchronized cycles, where a `filtLen` of 0 acts as 1. A pulse shorter than that has no effect on `count`.
- R7: A forward step taken while `count` is greater than or equal to `limit` sets `count` to 0 and raises `ovfPulse` for exactly one cycle.
- R8: A reverse step taken while `count` is 0 sets `count` to `limit` and raises `unfPulse` for exactly one cycle.
- R9: When both filtered channels change in the same cycle, `count` and `dirUp` stay unchanged and `errPulse` is raised for one cycle, in every mode and at every count value.
- R10: `dirUp` is 1 after a counted forward step and 0 after a counted reverse step.
- R11: `ovfPulse` and `unfPulse` are never high together. Between consecutive cycles, `count` changes only by one step or by a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Counting mode: 00 none, 01 A edges, 10 B edges, 11 all edges |
| filtLen | input | FILT_W | Minimum accepted pulse length in cycles (0 acts as 1) |
| limit | input | CNT_W | Highest count value before wrap |
| encA | input | 1 | Raw encoder channel A |
| encB | input | 1 | Raw encoder channel B |
| count | output | CNT_W | Position count |
| dirUp | output | 1 | 1 when the last counted step was forward |
| ovfPulse | output | 1 | One-cycle pulse on wrap from the limit to 0 |
| unfPulse | output | 1 | One-cycle pulse on wrap from 0 to the limit |
| errPulse | output | 1 | One-cycle pulse on an illegal double transition |

## Verification
The collision that matters is an illegal double transition arriving while the count sits at a wrap point. On that same sample the decoder could wrongly report both an error and a step. The bench provokes this by flipping both raw inputs on the same clock edge while the count is 0, and also by making random illegal flips while the limit is small. The pass condition is an error pulse with no change to the count, the direction flag, or the underflow and overflow tallies.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    QPC_HOLD   = 2'b00,
    QPC_ONLY_A = 2'b01,
    QPC_ONLY_B = 2'b10,
    QPC_BOTH   = 2'b11
  } qpc_mode_e;

  // strobes from the decoder to the counting datapath
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic illegal;
  } qpc_strobe_t;

  // next state in the forward Gray walk of the (B,A) pair
  function automatic logic [1:0] fwdNext(input logic [1:0] s);
    return {s[0], ~s[1]};
  endfunction

endpackage

// File: rtl/qpc_input_filter.sv
module qpc_input_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawIn,
  input  logic [FILT_W-1:0] filtLen,
  output logic              levelOut
);
  localparam int RUN_W = FILT_W + 1;

  logic [1:0]        syncQ;
  logic              syncd;
  logic [FILT_W-1:0] runLen;
  logic [RUN_W-1:0]  runNext;

  assign syncd   = syncQ[1];
  assign runNext = {1'b0, runLen} + RUN_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
    end
  end

  // a new level must persist for filtLen consecutive cycles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelOut <= 1'b0;
      runLen   <= '0;
    end else if (syncd == levelOut) begin
      runLen <= '0;
    end else if (runNext >= {1'b0, filtLen}) begin
      levelOut <= syncd;
      runLen   <= '0;
    end else begin
      runLen <= runNext[FILT_W-1:0];
    end
  end

endmodule

// File: rtl/qpc_decode_ctrl.sv
module qpc_decode_ctrl
  import qpc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  levels,
  input  logic [1:0]  mode,
  output qpc_strobe_t strobe
);
  qpc_mode_e  modeSel;
  logic [1:0] prevState;
  logic [1:0] changed;
  logic       isFwd;
  logic       isRev;
  logic       chanEnabled;
  logic       doubleHit;

  assign modeSel = qpc_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevState <= 2'b00;
    end else begin
      prevState <= levels;
    end
  end

  assign changed   = prevState ^ levels;
  assign doubleHit = &changed;
  assign isFwd     = (levels == fwdNext(prevState));
  assign isRev     = (prevState == fwdNext(levels));

  always_comb begin
    unique case (modeSel)
      QPC_ONLY_A: chanEnabled = changed[0];
      QPC_ONLY_B: chanEnabled = changed[1];
      QPC_BOTH:   chanEnabled = |changed;
      default:    chanEnabled = 1'b0;
    endcase
  end

  always_comb begin
    strobe          = '0;
    strobe.illegal  = doubleHit;
    strobe.stepUp   = chanEnabled && !doubleHit && isFwd;
    strobe.stepDown = chanEnabled && !doubleHit && isRev;
  end

endmodule

// File: rtl/qpc_count_dp.sv
module qpc_count_dp
  import qpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  qpc_strobe_t      strobe,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             dirUp,
  output logic             ovfPulse,
  output logic             unfPulse,
  output logic             errPulse
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      dirUp    <= 1'b1;
      ovfPulse <= 1'b0;
      unfPulse <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      ovfPulse <= 1'b0;
      unfPulse <= 1'b0;
      errPulse <= strobe.illegal;
      if (strobe.stepUp) begin
        dirUp <= 1'b1;
        if (count >= limit) begin
          count    <= '0;
          ovfPulse <= 1'b1;
        end else begin
          count <= count + CNT_W'(1);
        end
      end else if (strobe.stepDown) begin
        dirUp <= 1'b0;
        if (count == '0) begin
          count    <= limit;
          unfPulse <= 1'b1;
        end else begin
          count <= count - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [FILT_W-1:0] filtLen,
  input  logic [CNT_W-1:0]  limit,
  input  logic              encA,
  input  logic              encB,
  output logic [CNT_W-1:0]  count,
  output logic              dirUp,
  output logic              ovfPulse,
  output logic              unfPulse,
  output logic              errPulse
);
  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0] rawPair;
  logic [NUM_CH-1:0] levels;
  qpc_strobe_t       strobe;

  assign rawPair = {encB, encA};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    qpc_input_filter #(.FILT_W(FILT_W)) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (rawPair[ch]),
      .filtLen  (filtLen),
      .levelOut (levels[ch])
    );
  end

  qpc_decode_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .levels (levels),
    .mode   (mode),
    .strobe (strobe)
  );

  qpc_count_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .limit    (limit),
    .count    (count),
    .dirUp    (dirUp),
    .ovfPulse (ovfPulse),
    .unfPulse (unfPulse),
    .errPulse (errPulse)
  );

endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] limit,
  input logic [CNT_W-1:0] count,
  input logic             dirUp,
  input logic             ovfPulse,
  input logic             unfPulse,
  input logic             errPulse
);

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (!rstN -> (count == '0 && dirUp && !ovfPulse && !unfPulse && !errPulse))); // R1

  AST_OVF_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (count == '0)); // R7

  AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> !ovfPulse); // R7

  AST_UNF_TO_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    unfPulse |-> (count == $past(limit))); // R8

  AST_UNF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    unfPulse |=> !unfPulse); // R8

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> ($stable(count) && $stable(dirUp) && !ovfPulse && !unfPulse)); // R9

  AST_DIR_ON_OVF: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> dirUp); // R10

  AST_DIR_ON_UNF: assert property (@(posedge clk) disable iff (!rstN)
    unfPulse |-> !dirUp); // R10

  AST_NO_DOUBLE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfPulse && unfPulse)); // R11

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(count) |-> (ovfPulse || unfPulse ||
                         count == $past(count) + CNT_W'(1) ||
                         count == $past(count) - CNT_W'(1))); // R11

endmodule

bind quad_pos_counter qpc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .limit    (limit),
  .count    (count),
  .dirUp    (dirUp),
  .ovfPulse (ovfPulse),
  .unfPulse (unfPulse),
  .errPulse (errPulse)
);

// File: tb/quad_pos_counter_test.sv
module quad_pos_counter_test;
  localparam int CNT_W  = 16;
  localparam int FILT_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        mode = 2'b11;
  logic [FILT_W-1:0] filtLen = 4'd2;
  logic [CNT_W-1:0]  limit = 16'hFFFF;
  logic              encA = 1'b0;
  logic              encB = 1'b0;
  logic [CNT_W-1:0]  count;
  logic              dirUp;
  logic              ovfPulse;
  logic              unfPulse;
  logic              errPulse;

  int testsRun = 0;
  int testsFailed = 0;
  int ovfSeen = 0, unfSeen = 0, errSeen = 0;
  int widthBad = 0, bothBad = 0, stepBad = 0;
  logic ovfPrev = 1'b0, unfPrev = 1'b0, errPrev = 1'b0;
  logic [CNT_W-1:0] lastCount = '0;
  bit   finished = 1'b0;

  logic [1:0]       modelState = 2'b00;
  logic [CNT_W-1:0] expCount = '0;
  logic             expDir = 1'b1;
  int expOvf = 0, expUnf = 0, expErr = 0;

  always #2 clk = ~clk;

  quad_pos_counter #(.CNT_W(CNT_W), .FILT_W(FILT_W)) uut (
    .clk(clk), .rstN(rstN), .mode(mode), .filtLen(filtLen), .limit(limit),
    .encA(encA), .encB(encB), .count(count), .dirUp(dirUp),
    .ovfPulse(ovfPulse), .unfPulse(unfPulse), .errPulse(errPulse)
  );

  // pulse tallies and shape monitor (R7 R8 R9 R11)
  always @(negedge clk) begin
    if (rstN) begin
      if (ovfPulse) ovfSeen++;
      if (unfPulse) unfSeen++;
      if (errPulse) errSeen++;
      if ((ovfPulse && ovfPrev) || (unfPulse && unfPrev) || (errPulse && errPrev)) widthBad++;
      if (ovfPulse && unfPulse) bothBad++;
      if (count != lastCount && !ovfPulse && !unfPulse &&
          count != lastCount + 16'd1 && count != lastCount - 16'd1) stepBad++;
    end
    ovfPrev   = ovfPulse;
    unfPrev   = unfPulse;
    errPrev   = errPulse;
    lastCount = count;
  end

  function automatic logic [1:0] fwdTab(input logic [1:0] s);
    case (s)
      2'b00:   return 2'b01;
      2'b01:   return 2'b11;
      2'b11:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] revTab(input logic [1:0] s);
    case (s)
      2'b00:   return 2'b10;
      2'b10:   return 2'b11;
      2'b11:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic int effN();
    return (filtLen == 0) ? 1 : int'(filtLen);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic modelUpdate(input logic [1:0] ns);
    logic [1:0] diff;
    logic counts;
    diff = modelState ^ ns;
    if (diff == 2'b11) begin
      expErr++;
    end else if (diff != 2'b00) begin
      counts = (diff[0] && mode[0]) || (diff[1] && mode[1]);
      if (counts) begin
        if (ns == fwdTab(modelState)) begin
          expDir = 1'b1;
          if (expCount >= limit) begin expCount = '0; expOvf++; end
          else expCount = expCount + 16'd1;
        end else begin
          expDir = 1'b0;
          if (expCount == '0) begin expCount = limit; expUnf++; end
          else expCount = expCount - 16'd1;
        end
      end
    end
    modelState = ns;
  endtask

  task automatic checkAll(input string req);
    check(req, "count", 32'(count), 32'(expCount));
    check(req, "dirUp", 32'(dirUp), 32'(expDir));
    check("R7", "overflow tally", ovfSeen, expOvf);
    check("R8", "underflow tally", unfSeen, expUnf);
    check("R9", "error tally", errSeen, expErr);
  endtask

  task automatic goTo(input logic [1:0] ns, input string req);
    @(negedge clk);
    encB = ns[1];
    encA = ns[0];
    modelUpdate(ns);
    repeat (effN() + 8) @(negedge clk);
    checkAll(req);
  endtask

  task automatic fwdStep(input string req);
    goTo(fwdTab(modelState), req);
  endtask

  task automatic revStep(input string req);
    goTo(revTab(modelState), req);
  endtask

  task automatic illegalStep(input string req);
    goTo(~modelState, req);
  endtask

  task automatic glitchA(input int len, input string req);
    @(negedge clk);
    encA = ~encA;
    repeat (len) @(negedge clk);
    encA = ~encA;
    repeat (effN() + 8) @(negedge clk);
    checkAll(req);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd7781);
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "count", 32'(count), 32'd0);
    check("R1", "dirUp", 32'(dirUp), 32'd1);
    check("R1", "pulses", 32'({ovfPulse, unfPulse, errPulse}), 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 forward and reverse in all-edge mode
    mode = 2'b11; filtLen = 4'd2; limit = 16'hFFFF;
    for (int i = 0; i < 4; i++) fwdStep("R2");
    check("R2", "four forward steps", 32'(count), 32'd4);
    // R8 underflow through zero, R10 direction down
    for (int i = 0; i < 6; i++) revStep("R8");
    check("R8", "wrapped value", 32'(count), 32'hFFFE);
    check("R10", "dir after reverse", 32'(dirUp), 32'd0);
    // R7 overflow back to zero
    for (int i = 0; i < 2; i++) fwdStep("R7");
    check("R7", "wrapped to zero", 32'(count), 32'd0);
    check("R10", "dir after forward", 32'(dirUp), 32'd1);
    // R9 illegal double change while sitting at zero
    illegalStep("R9");
    check("R9", "no underflow at zero", 32'(unfSeen), 32'd1);

    // R3 channel A only
    mode = 2'b01;
    for (int i = 0; i < 4; i++) fwdStep("R3");
    // R4 channel B only
    mode = 2'b10;
    for (int i = 0; i < 4; i++) revStep("R4");
    // R5 hold mode
    mode = 2'b00;
    for (int i = 0; i < 4; i++) fwdStep("R5");
    illegalStep("R9");

    // R6 filter: a pulse one cycle short is dropped, a held step counts
    mode = 2'b11; filtLen = 4'd5;
    glitchA(4, "R6");
    fwdStep("R6");
    filtLen = 4'd0;
    glitchA(0, "R6");
    fwdStep("R6");

    // R7 small limit wraps
    filtLen = 4'd1; limit = 16'd3;
    for (int i = 0; i < 6; i++) fwdStep("R7");
    for (int i = 0; i < 6; i++) revStep("R8");

    // randomized walk
    for (int i = 0; i < 300; i++) begin
      int unsigned r;
      if (i % 25 == 0) begin
        @(negedge clk);
        mode    = 2'($urandom % 4);
        filtLen = FILT_W'($urandom % 8);
        limit   = ($urandom % 2 == 0) ? 16'hFFFF : 16'($urandom % 12);
      end
      r = $urandom % 100;
      if (r < 45) fwdStep("R2");
      else if (r < 85) revStep("R10");
      else if (r < 93) illegalStep("R9");
      else if (effN() >= 2) glitchA(effN() - 1, "R6");
      else fwdStep("R2");
    end

    check("R7", "pulse width", widthBad, 0);
    check("R11", "simultaneous wraps", bothBad, 0);
    check("R11", "count step size", stepBad, 0);
    finishRun();
  end

endmodule